// File: doc/BRIEF.md
# Power Mode and Clock Enable Controller

This block picks one of four operating modes for a small controller core: Normal, Green, Sleep and Idle. The choice comes from three writable bits in one control register and a halted flag that is set by a HALT strobe from the core. From the mode, the block drives an enable for the slow oscillator, an enable for the frequency multiplier that makes the fast clock, a select that chooses the fast clock as the CPU clock, and a CPU clock enable. The block only drives these enable and select levels. The oscillators, the multiplier and any glitch-free clock switching sit outside it.

Software changes the mode by writing the control register and by issuing HALT. A reset forces the part back to Green mode. An interrupt request or a falling edge on any pin of an 8-bit port also forces Green mode when the part is halted. Forcing Green mode clears the fast-select bit and the halted flag. The port is compared each cycle with a registered copy of its previous value, and only falling edges count.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control register sits at address 0x26. Bit 7 is the fast-select bit, bit 6 is the halt-oscillator-off bit and bit 5 is the multiplier-enable bit. Bits 4..0 always read 0, and a read at any other address returns 0x00.
- R2: With no halt pending, fast-select=1 and multiplier-enable=1 give Normal mode (mode_state=0): slow oscillator on, multiplier on, fast clock selected, CPU clock running.
- R3: With no halt pending and fast-select=0, the mode is Green (mode_state=1): slow oscillator on, multiplier off, slow clock selected, CPU clock running.
- R4: When halted with the register holding 0x00, the mode is Sleep (mode_state=2): slow oscillator on, multiplier off, slow clock selected, CPU clock stopped.
- R5: When halted with the register holding 0x40, the mode is Idle (mode_state=3): all enables and the select are 0.
- R6: A synchronous active-low reset clears the register to 0x00 and the halted flag, giving Green mode, from any mode.
- R7: An interrupt request while halted ends the halt and clears the fast-select bit from the next cycle on (Green mode). The other two bits keep their values.
- R8: A 1-to-0 transition on any port pin while halted wakes the part to Green mode in the same way. A 0-to-1 transition has no effect.
- R9: An interrupt or a port falling edge while not halted changes neither the mode nor the register.
- R10: Clearing fast-select while in Normal mode gives Green mode and leaves multiplier-enable at 1 on readback.
- R11: Any state not listed in R2, R4 and R5 decodes as Green mode. This includes fast-select=1 with multiplier-enable=0, and halted with multiplier-enable=1.
- R12: When a register write and a wake event fall in the same cycle, the written multiplier-enable and halt-oscillator-off values are kept, fast-select ends at 0 and the halt ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data (combinational) |
| halt_req | input | 1 | One-cycle HALT strobe from the core |
| irq | input | 1 | Interrupt request |
| port_in | input | 8 | Port pins watched for falling edges |
| slow_osc_en | output | 1 | Slow oscillator enable |
| fast_clk_en | output | 1 | Frequency multiplier enable |
| sysclk_sel_fast | output | 1 | 1 selects the fast clock as the CPU clock |
| cpu_clk_en | output | 1 | CPU clock running |
| mode_state | output | 2 | Current mode: 0 Normal, 1 Green, 2 Sleep, 3 Idle |

## Verification
A register write and a wake event can land on the same clock edge. Both act on the fast-select bit, and the wake also clears the halted flag. The bench halts the part in Sleep mode. It then asserts a write of 0xE0 and an interrupt request together for one cycle. After that edge it expects a readback of 0x60 and Green mode, so the wake wins on fast-select and ends the halt, while the written values of the other bits are kept.

// File: rtl/pmc_pkg.sv
// Shared types and constants for the power mode controller.
// Assumes an 8-bit control register with the three mode bits in the top byte positions.
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_GREEN  = 2'd1,
        PM_SLEEP  = 2'd2,
        PM_IDLE   = 2'd3
    } pm_mode_e;

    localparam int CTRL_W       = 8;
    localparam int FAST_SEL_BIT = 7;
    localparam int OSC_OFF_BIT  = 6;
    localparam int MULT_EN_BIT  = 5;

    localparam logic [CTRL_W-1:0] CTRL_WR_MASK =
        (CTRL_W'(1) << FAST_SEL_BIT) | (CTRL_W'(1) << OSC_OFF_BIT) | (CTRL_W'(1) << MULT_EN_BIT);

    typedef struct packed {
        logic slow_en;
        logic fast_en;
        logic sel_fast;
        logic cpu_en;
    } clk_ctl_t;

endpackage

// File: rtl/pmc_edge_detect.sv
// Falling-edge detector for the wake-up port.
// Keeps a registered copy of the port and flags each bit that went from 1 to 0.
// Assumes the port is already synchronous to clk. During reset the copy follows
// the port, so a level held low across reset does not count as an edge.
module pmc_edge_detect #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_i,
    output logic [PORT_W-1:0] fall_o
);

    logic [PORT_W-1:0] prev_q;

    // Previous-cycle copy of the port (also loaded while in reset)
    always_ff @(posedge clk) begin
        prev_q <= port_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < PORT_W; gi++) begin : g_bit
            // Per-pin falling edge: high last cycle, low now
            always_comb begin
                fall_o[gi] = prev_q[gi] & ~port_i[gi];
            end
        end
    endgenerate

    // R8
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o != '0) |-> ((($past(port_i) & ~port_i)) == fall_o));

endmodule

// File: rtl/pmc_ctrl_reg.sv
// Mode control register and halted flag.
// Holds the three writable mode bits (reserved bits are masked to 0) and the halted flag.
// A wake event (interrupt or port edge while halted) clears fast-select and the halted flag.
// If a wake and a write land on the same edge, the wake takes priority on fast-select.
module pmc_ctrl_reg
    import pmc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              halt_req_i,
    input  logic              wake_src_i,
    output logic              halted_o,
    output logic              fast_sel_o,
    output logic              osc_off_o,
    output logic              mult_en_o
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              halted_q;
    logic              hit;
    logic              wake;

    // Address decode and wake qualification
    always_comb begin
        hit  = (addr_i == CTRL_ADDR);
        wake = halted_q & wake_src_i;
    end

    // Control register: masked write, then wake clears fast-select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en_i && hit) begin
                ctrl_q <= wr_data_i & CTRL_WR_MASK;
            end
            if (wake) begin
                ctrl_q[FAST_SEL_BIT] <= 1'b0;
            end
        end
    end

    // Halted flag: set by HALT strobe, cleared by wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
        end else if (wake) begin
            halted_q <= 1'b0;
        end else if (halt_req_i) begin
            halted_q <= 1'b1;
        end
    end

    // Read mux and field outputs
    always_comb begin
        rd_data_o  = hit ? ctrl_q : '0;
        halted_o   = halted_q;
        fast_sel_o = ctrl_q[FAST_SEL_BIT];
        osc_off_o  = ctrl_q[OSC_OFF_BIT];
        mult_en_o  = ctrl_q[MULT_EN_BIT];
    end

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o[FAST_SEL_BIT] == 1'b0 && !fast_sel_o && !osc_off_o && !mult_en_o && !halted_o));

    // R7
    wake_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && wake_src_i) |=> (!halted_o && !fast_sel_o));

    // R9
    awake_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && !wr_en_i) |=> ($stable(fast_sel_o) && $stable(mult_en_o) && $stable(osc_off_o)));

endmodule

// File: rtl/pmc_mode_decode.sv
// Mode decoder: maps the halted flag and the mode bits to a mode and clock controls.
// Only the three table rows (Normal, Sleep, Idle) are decoded explicitly. Everything
// else, including the ordinary Green row, falls to Green.
module pmc_mode_decode
    import pmc_pkg::*;
(
    input  logic     halted_i,
    input  logic     fast_sel_i,
    input  logic     osc_off_i,
    input  logic     mult_en_i,
    output pm_mode_e mode_o,
    output clk_ctl_t ctl_o
);

    // Pick the mode from the register bits and the halted state
    always_comb begin
        if (!halted_i && fast_sel_i && mult_en_i) begin
            mode_o = PM_NORMAL;
        end else if (halted_i && !fast_sel_i && !mult_en_i && !osc_off_i) begin
            mode_o = PM_SLEEP;
        end else if (halted_i && !fast_sel_i && !mult_en_i && osc_off_i) begin
            mode_o = PM_IDLE;
        end else begin
            mode_o = PM_GREEN;
        end
    end

    // Clock controls for each mode
    always_comb begin
        unique case (mode_o)
            PM_NORMAL: ctl_o = '{slow_en: 1'b1, fast_en: 1'b1, sel_fast: 1'b1, cpu_en: 1'b1};
            PM_SLEEP:  ctl_o = '{slow_en: 1'b1, fast_en: 1'b0, sel_fast: 1'b0, cpu_en: 1'b0};
            PM_IDLE:   ctl_o = '{slow_en: 1'b0, fast_en: 1'b0, sel_fast: 1'b0, cpu_en: 1'b0};
            default:   ctl_o = '{slow_en: 1'b1, fast_en: 1'b0, sel_fast: 1'b0, cpu_en: 1'b1};
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode and clock enable controller (top).
// Connects the port edge detector, the control register and the mode decoder.
// Assumes all inputs are synchronous to clk. The outputs are levels for external
// oscillator, multiplier and clock-switch logic.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h26,
    parameter int                PORT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_data,
    output logic [7:0]        reg_rd_data,
    input  logic              halt_req,
    input  logic              irq,
    input  logic [PORT_W-1:0] port_in,
    output logic              slow_osc_en,
    output logic              fast_clk_en,
    output logic              sysclk_sel_fast,
    output logic              cpu_clk_en,
    output logic [1:0]        mode_state
);

    logic [PORT_W-1:0] port_fall;
    logic              wake_src;
    logic              halted;
    logic              fast_sel;
    logic              osc_off;
    logic              mult_en;
    pm_mode_e          mode;
    clk_ctl_t          ctl;

    pmc_edge_detect #(.PORT_W(PORT_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .port_i (port_in),
        .fall_o (port_fall)
    );

    // Any wake source: interrupt or a falling edge on any pin
    always_comb begin
        wake_src = irq | (|port_fall);
    end

    pmc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_en_i    (reg_wr_en),
        .wr_data_i  (reg_wr_data),
        .rd_data_o  (reg_rd_data),
        .halt_req_i (halt_req),
        .wake_src_i (wake_src),
        .halted_o   (halted),
        .fast_sel_o (fast_sel),
        .osc_off_o  (osc_off),
        .mult_en_o  (mult_en)
    );

    pmc_mode_decode u_dec (
        .halted_i   (halted),
        .fast_sel_i (fast_sel),
        .osc_off_i  (osc_off),
        .mult_en_i  (mult_en),
        .mode_o     (mode),
        .ctl_o      (ctl)
    );

    // Drive the output pins from the decoded controls
    always_comb begin
        slow_osc_en     = ctl.slow_en;
        fast_clk_en     = ctl.fast_en;
        sysclk_sel_fast = ctl.sel_fast;
        cpu_clk_en      = ctl.cpu_en;
        mode_state      = mode;
    end

    // R2
    fast_sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_sel_fast |-> fast_clk_en);

    // R4
    cpu_stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> ($past(halt_req) || $past(reg_wr_en)));

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h26;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       halt_req = 1'b0;
    logic       irq = 1'b0;
    logic [7:0] port_in = 8'hFF;
    logic       slow_osc_en, fast_clk_en, sysclk_sel_fast, cpu_clk_en;
    logic [1:0] mode_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [7:0] EXP_NORMAL = {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00};
    localparam logic [7:0] EXP_GREEN  = {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00};
    localparam logic [7:0] EXP_SLEEP  = {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00};
    localparam logic [7:0] EXP_IDLE   = {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00};

    always #2.5 clk = ~clk;

    pwr_mode_ctrl uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_addr        (reg_addr),
        .reg_wr_en       (reg_wr_en),
        .reg_wr_data     (reg_wr_data),
        .reg_rd_data     (reg_rd_data),
        .halt_req        (halt_req),
        .irq             (irq),
        .port_in         (port_in),
        .slow_osc_en     (slow_osc_en),
        .fast_clk_en     (fast_clk_en),
        .sysclk_sel_fast (sysclk_sel_fast),
        .cpu_clk_en      (cpu_clk_en),
        .mode_state      (mode_state)
    );

    function automatic logic [7:0] outs();
        return {mode_state, slow_osc_en, fast_clk_en, sysclk_sel_fast, cpu_clk_en, 2'b00};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_halt();
        @(negedge clk); halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq = 1'b1;
        @(negedge clk); irq = 1'b0;
    endtask

    task automatic set_port(input logic [7:0] v);
        @(negedge clk); port_in = v;
        @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R6 reset outputs", outs(), EXP_GREEN);
        check("R6 reset register", reg_rd_data, 8'h00);
    endtask

    task automatic t_layout();
        wr(8'hFF);
        check("R1 reserved bits read 0", reg_rd_data, 8'hE0);
        reg_addr = 8'h27; #0.5;
        check("R1 other address reads 0", reg_rd_data, 8'h00);
        reg_addr = 8'h26; #0.5;
        check("R11 fast-select with halt-osc bit, awake", outs(), EXP_NORMAL);
        wr(8'h00);
    endtask

    task automatic t_normal_green();
        wr(8'hA0);
        check("R2 normal outputs", outs(), EXP_NORMAL);
        pulse_irq();
        check("R9 irq awake keeps normal", outs(), EXP_NORMAL);
        check("R9 irq awake keeps register", reg_rd_data, 8'hA0);
        wr(8'h20);
        check("R10 normal to green outputs", outs(), EXP_GREEN);
        check("R10 multiplier bit kept", reg_rd_data, 8'h20);
        wr(8'h00);
        check("R3 green outputs", outs(), EXP_GREEN);
    endtask

    task automatic t_sleep_irq();
        wr(8'h00);
        do_halt();
        check("R4 sleep outputs", outs(), EXP_SLEEP);
        pulse_irq();
        check("R7 irq wakes to green", outs(), EXP_GREEN);
        check("R7 register after wake", reg_rd_data, 8'h00);
    endtask

    task automatic t_idle_port();
        wr(8'h40);
        set_port(8'hF7);
        check("R9 port fall awake no effect", outs(), EXP_GREEN);
        check("R9 port fall awake register", reg_rd_data, 8'h40);
        do_halt();
        check("R5 idle outputs", outs(), EXP_IDLE);
        set_port(8'hFF);
        check("R8 rising edge keeps idle", outs(), EXP_IDLE);
        set_port(8'hFE);
        check("R8 falling edge wakes", outs(), EXP_GREEN);
        check("R8 register after wake", reg_rd_data, 8'h40);
        set_port(8'hFF);
    endtask

    task automatic t_unlisted();
        wr(8'h80);
        check("R11 fast-select without multiplier", outs(), EXP_GREEN);
        wr(8'h20);
        do_halt();
        check("R11 halted with multiplier on", outs(), EXP_GREEN);
        pulse_irq();
        check("R7 wake keeps multiplier bit", reg_rd_data, 8'h20);
        wr(8'h00);
        check("R7 halt cleared so awake", outs(), EXP_GREEN);
    endtask

    task automatic t_collide();
        wr(8'h00);
        do_halt();
        check("R12 sleep before collision", outs(), EXP_SLEEP);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 8'hE0; irq = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; irq = 1'b0;
        check("R12 register after collision", reg_rd_data, 8'h60);
        check("R12 mode after collision", outs(), EXP_GREEN);
    endtask

    task automatic t_reset_mid();
        wr(8'hA0);
        check("R6 normal before reset", outs(), EXP_NORMAL);
        apply_reset();
        check("R6 reset from normal", outs(), EXP_GREEN);
        check("R6 reset clears register", reg_rd_data, 8'h00);
        wr(8'h00);
        do_halt();
        apply_reset();
        check("R6 reset from sleep", outs(), EXP_GREEN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_normal_green();
        t_sleep_irq();
        t_idle_port();
        t_unlisted();
        t_collide();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule